// File: doc/BRIEF.md
# Tuner Control Command Slave

This block is the byte-level half of a two-wire serial slave that programs a frequency synthesizer. A bit-level deserializer in front of it reports four kinds of events: a START condition, a STOP condition, a complete received byte, and the master's acknowledge bit during reads. The block decides whether the address byte is meant for it, acknowledges or refuses it, and then either routes written bytes into the tuning registers or supplies status bytes for the serializer to shift out.

Written data has no register index. The leading bit of the first byte of each pair selects the destination. A leading 0 starts a divider pair: the seven high divider bits come first, then the low eight. A leading 1 starts a control/port pair: a control byte, then a port-enable byte. After a pair completes, the next byte is classified again by its leading bit. A transfer can therefore begin at either pair and run on without re-addressing until STOP. This lets a host sweep the divide ratio with back-to-back pairs. The divider output only ever changes as a whole.

In read mode the block returns a status byte with a power-on flag, the loop-lock flag, three general-purpose input levels and a three-bit converter code. The power-on flag clears when the master ends the read with a not-acknowledge.

Top module: `tuner_ctl_slave`

## Requirements
- R1: After reset the divider output is 0, every port enable is 0 (high impedance), all control outputs are 0, the power-on flag is 1, and no acknowledge or transmit strobe is active.
- R2: The address byte is `11000 S1 S0 D`. When S1:S0 equals `addr_sel`, the block returns `ack_valid`=1 with `ack`=1 one cycle after the byte strobe. On any other address it returns `ack`=0 and ignores every later byte and master-acknowledge event until the next START.
- R3: Byte events that arrive after a STOP and before a START give no acknowledge and change no register.
- R4: A first byte with bit7=0 holds bits 6:0 as divider bits 14:8. The divider output keeps its old value until the next byte arrives. That byte supplies bits 7:0, and the whole 15-bit value then appears at once.
- R5: A first byte with bit7=1 is the control byte: bit6 sets `cp_high`, bit5 sets `test_ref`, bit4 sets `cp_tristate`, and bit0 sets `amp_off`.
- R6: The byte after a control byte is the port byte. `port_en` = {bit7, bit6, bit5, bit4, bit3, bit0}. Bits 2:1 are ignored.
- R7: After any completed pair, the next byte is classified again by its bit7. A transfer may start with either pair and may continue with further pairs until STOP.
- R8: Every data byte of an addressed write is acknowledged one cycle after its strobe.
- R9: For an address with D=1, the block acknowledges and pulses `tx_load` with `tx_byte` = {por_flag, lock, gp_in[2:0], adc_in[2:0]}, sampled in that cycle. A master acknowledge of 1 produces another `tx_load`. A master acknowledge of 0 produces none and ends the read.
- R10: The power-on flag is cleared in the cycle after a read ends with a master not-acknowledge, and it stays 0.
- R11: START or STOP returns the pair position to the first byte. A half-written divider pair leaves the divider output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| ev_start | input | 1 | START condition seen |
| ev_stop | input | 1 | STOP condition seen |
| ev_byte | input | 1 | A received byte is valid on rx_byte |
| rx_byte | input | 8 | Received byte |
| ev_mack | input | 1 | Master acknowledge bit valid (read mode) |
| mack | input | 1 | Master acknowledge value, 1 = acknowledge |
| addr_sel | input | 2 | Selected programmable address code |
| lock | input | 1 | Loop in-lock indication |
| gp_in | input | 3 | General-purpose port input levels |
| adc_in | input | 3 | Converter code for status |
| ack_valid | output | 1 | Pulse: ack holds the slave's response |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| tx_load | output | 1 | Pulse: load tx_byte into the serializer |
| tx_byte | output | 8 | Status byte to transmit |
| divider | output | 15 | Committed divide ratio |
| cp_high | output | 1 | High charge-pump current select |
| test_ref | output | 1 | Route reference/divider to test ports |
| cp_tristate | output | 1 | Charge pump high impedance |
| amp_off | output | 1 | Varicap drive amplifier off |
| port_en | output | 6 | Port drive enables, 0 = high impedance |
| por_flag | output | 1 | Power-on flag |

## Verification
The bench uses the default divider width of 15 and the default fixed address prefix `11000`, with `addr_sel` tied to 2. Write addresses are therefore 0xC4, read addresses 0xC5, and 0xC0 is a foreign address. With these values the bench reaches the largest divider value 0x7FFF, the split between the 7-bit high byte and the 8-bit low byte, and a mismatch in the select bits alone. The status byte packs one bit per flag, so the flag positions and the converter and input fields can each be seen directly.

// File: rtl/tuner_pkg.sv
package tuner_pkg;
    localparam int BYTE_W   = 8;
    localparam int PORT_N   = 6;
    localparam int GP_W     = 3;
    localparam int ADC_W    = 3;
    localparam int SEL_W    = 2;
    localparam int PREFIX_W = BYTE_W - SEL_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WR,
        ST_RD,
        ST_SKIP
    } link_state_t;

    typedef enum logic [1:0] {
        POS_HEAD,
        POS_DIV_LO,
        POS_PORT
    } pair_pos_t;

    typedef struct packed {
        logic cp_high;
        logic test_ref;
        logic cp_tristate;
        logic amp_off;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [BYTE_W-1:0] b);
        ctrl_t c;
        c.cp_high     = b[6];
        c.test_ref    = b[5];
        c.cp_tristate = b[4];
        c.amp_off     = b[0];
        return c;
    endfunction

    function automatic logic [PORT_N-1:0] unpack_ports(input logic [BYTE_W-1:0] b);
        return {b[7], b[6], b[5], b[4], b[3], b[0]};
    endfunction
endpackage

// File: rtl/tuner_addr_dec.sv
module tuner_addr_dec
    import tuner_pkg::*;
#(
    parameter logic [PREFIX_W-1:0] PREFIX = 5'b11000
) (
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic [SEL_W-1:0]  sel,
    output logic              hit,
    output logic              is_read
);
    always_comb begin
        hit     = (addr_byte[BYTE_W-1 -: PREFIX_W] == PREFIX) &&
                  (addr_byte[SEL_W:1] == sel);
        is_read = addr_byte[0];
    end
endmodule

// File: rtl/tuner_wr_steer.sv
module tuner_wr_steer
    import tuner_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    output logic [DIV_W-1:0]  div_q,
    output ctrl_t             ctrl_q,
    output logic [PORT_N-1:0] port_q
);
    localparam int HI_W = DIV_W - BYTE_W;

    pair_pos_t       pos;
    logic [HI_W-1:0] hi_stage;
    logic            lo_evt;
    logic            port_evt;

    always_comb begin
        lo_evt   = wr_en && !restart && (pos == POS_DIV_LO);
        port_evt = wr_en && !restart && (pos == POS_PORT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos      <= POS_HEAD;
            hi_stage <= '0;
            div_q    <= '0;
            ctrl_q   <= '0;
            port_q   <= '0;
        end else if (restart) begin
            pos <= POS_HEAD;
        end else if (wr_en) begin
            case (pos)
                POS_HEAD: begin
                    if (!wr_byte[BYTE_W-1]) begin
                        hi_stage <= wr_byte[HI_W-1:0];
                        pos      <= POS_DIV_LO;
                    end else begin
                        ctrl_q <= unpack_ctrl(wr_byte);
                        pos    <= POS_PORT;
                    end
                end
                POS_DIV_LO: begin
                    div_q <= {hi_stage, wr_byte};
                    pos   <= POS_HEAD;
                end
                POS_PORT: begin
                    port_q <= unpack_ports(wr_byte);
                    pos    <= POS_HEAD;
                end
                default: pos <= POS_HEAD;
            endcase
        end
    end

    AST_DIV_ONLY_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(div_q) |-> $past(lo_evt)) else $error("divider moved off pair end"); // R4
    AST_PORT_ONLY_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
        !$stable(port_q) |-> $past(port_evt)) else $error("ports moved off port byte"); // R6
    AST_RESTART_TO_HEAD: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pos == POS_HEAD)) else $error("position not reset"); // R11
endmodule

// File: rtl/tuner_rd_status.sv
module tuner_rd_status
    import tuner_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              finish,
    input  logic              lock,
    input  logic [GP_W-1:0]   gp_in,
    input  logic [ADC_W-1:0]  adc_in,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              por_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_load <= 1'b0;
            tx_byte <= '0;
            por_q   <= 1'b1;
        end else begin
            tx_load <= load;
            if (load) tx_byte <= {por_q, lock, gp_in, adc_in};
            if (finish) por_q <= 1'b0;
        end
    end

    AST_POR_CLEARS_ON_END: assert property (@(posedge clk) disable iff (rst)
        $fell(por_q) |-> $past(finish)) else $error("flag cleared without read end"); // R10
    AST_POR_NEVER_RISES: assert property (@(posedge clk) disable iff (rst)
        !$rose(por_q)) else $error("flag set again"); // R10
endmodule

// File: rtl/tuner_ctl_slave.sv
module tuner_ctl_slave
    import tuner_pkg::*;
#(
    parameter int                  DIV_W  = 15,
    parameter logic [PREFIX_W-1:0] PREFIX = 5'b11000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_stop,
    input  logic              ev_byte,
    input  logic [7:0]        rx_byte,
    input  logic              ev_mack,
    input  logic              mack,
    input  logic [1:0]        addr_sel,
    input  logic              lock,
    input  logic [2:0]        gp_in,
    input  logic [2:0]        adc_in,
    output logic              ack_valid,
    output logic              ack,
    output logic              tx_load,
    output logic [7:0]        tx_byte,
    output logic [DIV_W-1:0]  divider,
    output logic              cp_high,
    output logic              test_ref,
    output logic              cp_tristate,
    output logic              amp_off,
    output logic [5:0]        port_en,
    output logic              por_flag
);
    link_state_t state;
    logic        hit, is_read;
    logic        bus_evt, byte_evt, wr_en, rd_load, rd_finish;
    ctrl_t       ctrl;

    tuner_addr_dec #(.PREFIX(PREFIX)) u_dec (
        .addr_byte (rx_byte),
        .sel       (addr_sel),
        .hit       (hit),
        .is_read   (is_read)
    );

    always_comb begin
        bus_evt   = ev_start || ev_stop;
        byte_evt  = ev_byte && !bus_evt;
        wr_en     = byte_evt && (state == ST_WR);
        rd_load   = (byte_evt && (state == ST_ADDR) && hit && is_read) ||
                    (ev_mack && !bus_evt && (state == ST_RD) && mack);
        rd_finish = ev_mack && !bus_evt && (state == ST_RD) && !mack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ack_valid <= 1'b0;
            ack       <= 1'b0;
        end else begin
            ack_valid <= 1'b0;
            if (ev_stop) begin
                state <= ST_IDLE;
            end else if (ev_start) begin
                state <= ST_ADDR;
            end else if (ev_byte) begin
                case (state)
                    ST_ADDR: begin
                        ack_valid <= 1'b1;
                        ack       <= hit;
                        if (!hit)         state <= ST_SKIP;
                        else if (is_read) state <= ST_RD;
                        else              state <= ST_WR;
                    end
                    ST_WR: begin
                        ack_valid <= 1'b1;
                        ack       <= 1'b1;
                    end
                    default: ;
                endcase
            end else if (rd_finish) begin
                state <= ST_SKIP;
            end
        end
    end

    tuner_wr_steer #(.DIV_W(DIV_W)) u_wr (
        .clk     (clk),
        .rst     (rst),
        .restart (bus_evt),
        .wr_en   (wr_en),
        .wr_byte (rx_byte),
        .div_q   (divider),
        .ctrl_q  (ctrl),
        .port_q  (port_en)
    );

    tuner_rd_status u_rd (
        .clk     (clk),
        .rst     (rst),
        .load    (rd_load),
        .finish  (rd_finish),
        .lock    (lock),
        .gp_in   (gp_in),
        .adc_in  (adc_in),
        .tx_load (tx_load),
        .tx_byte (tx_byte),
        .por_q   (por_flag)
    );

    always_comb begin
        cp_high     = ctrl.cp_high;
        test_ref    = ctrl.test_ref;
        cp_tristate = ctrl.cp_tristate;
        amp_off     = ctrl.amp_off;
    end

    AST_NACK_SKIPS: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !ack) |-> (state == ST_SKIP)) else $error("nack without skip"); // R2
    AST_TX_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> (state == ST_RD)) else $error("transmit outside read"); // R9
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_IDLE) && ev_byte && !bus_evt) |=> !ack_valid) else $error("ack while idle"); // R3
    AST_NO_DOUBLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(ack_valid && tx_load && !ack)) else $error("load after refusal"); // R9
endmodule

// File: tb/tuner_ctl_slave_test.sv
`timescale 1ns/1ps
module tuner_ctl_slave_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_start = 0, ev_stop = 0, ev_byte = 0, ev_mack = 0, mack = 0;
    logic [7:0] rx_byte = '0;
    logic [1:0] addr_sel = 2'd2;
    logic lock = 0;
    logic [2:0] gp_in = '0, adc_in = '0;
    logic ack_valid, ack, tx_load;
    logic [7:0] tx_byte;
    logic [14:0] divider;
    logic cp_high, test_ref, cp_tristate, amp_off, por_flag;
    logic [5:0] port_en;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    tuner_ctl_slave uut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); ev_start = 1;
        @(negedge clk); ev_start = 0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); ev_stop = 1;
        @(negedge clk); ev_stop = 0;
    endtask

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk); ev_byte = 1; rx_byte = b;
        @(negedge clk); ev_byte = 0;
    endtask

    task automatic put_mack(input logic a);
        @(negedge clk); ev_mack = 1; mack = a;
        @(negedge clk); ev_mack = 0;
    endtask

    task automatic t_reset();
        chk("R1 divider", divider, 0);
        chk("R1 ports", port_en, 0);
        chk("R1 ctrl", {cp_high, test_ref, cp_tristate, amp_off}, 0);
        chk("R1 por", por_flag, 1);
        chk("R1 strobes", {ack_valid, tx_load}, 0);
    endtask

    task automatic t_full_write();
        pulse_start();
        put_byte(8'hC4);
        chk("R2 addr ack", {ack_valid, ack}, 2'b11);
        put_byte(8'h12);
        chk("R8 data ack", {ack_valid, ack}, 2'b11);
        chk("R4 no half write", divider, 0);
        put_byte(8'h34);
        chk("R4 divider commit", divider, 15'h1234);
        put_byte(8'hC1);
        chk("R5 ctrl", {cp_high, test_ref, cp_tristate, amp_off}, 4'b1001);
        chk("R6 ports before byte", port_en, 0);
        put_byte(8'hF9);
        chk("R6 ports", port_en, 6'h3F);
        pulse_stop();
    endtask

    task automatic t_sweep();
        pulse_start();
        put_byte(8'hC4);
        put_byte(8'h01); put_byte(8'h00);
        chk("R7 sweep 1", divider, 15'h0100);
        put_byte(8'h7F); put_byte(8'hFF);
        chk("R7 sweep 2", divider, 15'h7FFF);
        pulse_stop();
    endtask

    task automatic t_ctrl_first();
        pulse_start();
        put_byte(8'hC4);
        put_byte(8'hB0);
        chk("R5 ctrl start", {cp_high, test_ref, cp_tristate, amp_off}, 4'b0110);
        put_byte(8'h17);
        chk("R6 port bits 2:1 ignored", port_en, 6'b000101);
        chk("R7 divider untouched", divider, 15'h7FFF);
        pulse_stop();
    endtask

    task automatic t_mismatch();
        pulse_start();
        put_byte(8'hC0);
        chk("R2 nack", {ack_valid, ack}, 2'b10);
        put_byte(8'h05);
        chk("R2 ignored ack", ack_valid, 0);
        put_byte(8'h06);
        chk("R2 ignored data", divider, 15'h7FFF);
        pulse_stop();
    endtask

    task automatic t_no_start();
        put_byte(8'h03);
        chk("R3 no ack", ack_valid, 0);
        put_byte(8'h04);
        chk("R3 no change", divider, 15'h7FFF);
    endtask

    task automatic t_stop_midpair();
        pulse_start();
        put_byte(8'hC4);
        put_byte(8'h22);
        pulse_stop();
        chk("R11 half pair dropped", divider, 15'h7FFF);
        pulse_start();
        put_byte(8'hC4);
        put_byte(8'h33); put_byte(8'h44);
        chk("R11 fresh head", divider, 15'h3344);
        pulse_stop();
    endtask

    task automatic t_restart();
        pulse_start();
        put_byte(8'hC4);
        put_byte(8'h05);
        pulse_start();
        put_byte(8'hC4);
        put_byte(8'h06); put_byte(8'h07);
        chk("R11 repeated start", divider, 15'h0607);
        pulse_stop();
    endtask

    task automatic t_read();
        lock = 1; gp_in = 3'b101; adc_in = 3'b010;
        pulse_start();
        put_byte(8'hC5);
        chk("R9 read ack", {ack_valid, ack, tx_load}, 3'b111);
        chk("R9 status", tx_byte, 8'hEA);
        lock = 0;
        put_mack(1'b1);
        chk("R9 second load", tx_load, 1);
        chk("R9 status 2", tx_byte, 8'hAA);
        chk("R10 por held", por_flag, 1);
        put_mack(1'b0);
        chk("R9 no load on nack", tx_load, 0);
        chk("R10 por cleared", por_flag, 0);
        pulse_stop();
        pulse_start();
        put_byte(8'hC5);
        chk("R10 status after clear", tx_byte, 8'h2A);
        put_mack(1'b0);
        pulse_stop();
        chk("R10 stays clear", por_flag, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_full_write();
        t_sweep();
        t_ctrl_first();
        t_mismatch();
        t_no_start();
        t_stop_midpair();
        t_restart();
        t_read();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule